// File: doc/BRIEF.md
# I2C Line Monitor with Software Override

This block sits between the open-drain SCL and SDA pads and the transfer engine of an I2C controller. Each raw pad input first passes through a two-flop synchronizer. It then goes through a spike filter whose length, in system clocks, is programmable. The filtered levels go to the transfer engine and also appear in a 4-bit monitor word that software reads.

The same monitor word holds two override bits, one for each line. While an override bit is set, that line is pulled low no matter what the transfer engine requests. Software uses this to clock SCL by hand and free a slave that is holding SDA low. Each pull-low output to the pad is the OR of the software override and the engine's own pull-low request. The two override fields have separate write enables, so writing one never disturbs the other.

Each line's filter is a two-state machine:
- `FLT_STABLE`: the output equals the last accepted level. When the synchronized input differs from the output, one of two transitions follows:
  - with a zero filter length it commits at once (transition *stable-commit*);
  - otherwise it moves to `FLT_QUAL` with the run count at 1 (transition *start-qualify*).
- `FLT_QUAL`: the new level is being qualified. Two transitions lead back to `FLT_STABLE`:
  - if the input returns to the accepted level before the count is reached, the filter drops back and the count is discarded (transition *reject-bounce*);
  - if the input is still different once the count has reached the filter length, the output takes the new level (transition *qualify-commit*).
- While neither transition applies, the filter stays in `FLT_QUAL` and the count increments.

Top module: `i2c_line_watch`

## Requirements
- R1: After reset both override bits are 0, both filtered levels are 1, and the monitor word reads 4'b0011.
- R2: The monitor word has this bit map: bit 0 is the filtered SCL level, bit 1 is the filtered SDA level, bit 2 is the SCL override and bit 3 is the SDA override.
- R3: When a pad holds a new level, the filtered output for that line takes the new level on exactly the (L+3)th rising clock edge after the pad change, where L is the filter length. Two of those edges are synchronizer delay.
- R4: A pad pulse that lasts L clocks or fewer never reaches the filtered output. A pulse of L+1 clocks or more does reach it.
- R5: If the pad returns to the accepted level during qualification, the count is discarded. The next change is again timed in full from its own start, as in R3.
- R6: Writing the SCL override field (write enable bit 0, data bit 0) updates it on the next clock edge and leaves the SDA override unchanged. While the SCL override is 1, the SCL pull-low output is 1.
- R7: Writing the SDA override field (write enable bit 1, data bit 1) updates it on the next clock edge and leaves the SCL override unchanged. While the SDA override is 1, the SDA pull-low output is 1.
- R8: Each pull-low output is 1 exactly when its override bit or the engine's pull-low request for that line is 1. The engine request takes effect without a clock delay.
- R9: With a filter length of 0, a pad change reaches the filtered output on the 3rd rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pad_i | input | 1 | Raw SCL pad input |
| sda_pad_i | input | 1 | Raw SDA pad input |
| eng_scl_pull_i | input | 1 | Transfer engine request to pull SCL low |
| eng_sda_pull_i | input | 1 | Transfer engine request to pull SDA low |
| glitch_len_i | input | FLT_W | Spike filter length in clocks, shared by both lines |
| force_we_i | input | 2 | Field write enables: bit 0 for the SCL override, bit 1 for the SDA override |
| force_wd_i | input | 2 | Override write data: bit 0 for SCL, bit 1 for SDA |
| mon_o | output | 4 | Monitor word, bit map as in R2 |
| scl_level_o | output | 1 | Filtered SCL level to the engine |
| sda_level_o | output | 1 | Filtered SDA level to the engine |
| scl_pull_o | output | 1 | SCL open-drain pull-low enable |
| sda_pull_o | output | 1 | SDA open-drain pull-low enable |

## Verification
The filter assertions assume that the filter length does not change while a line is in qualification. If the length dropped below the running count, a commit would fire early, and the count bound would no longer describe the state correctly. The bench therefore writes a new length only after both lines have been quiet longer than the longest qualification window. The override assertions assume nothing about the pads, because the pad model never loops the pull-low outputs back onto the pad inputs. Pad and override stimulus is applied on falling edges, so every expected commit edge can be counted exactly.

// File: rtl/i2c_lw_pkg.sv
package i2c_lw_pkg;
    typedef enum logic {
        FLT_STABLE = 1'b0,
        FLT_QUAL   = 1'b1
    } flt_state_e;

    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;
    localparam int NUM_LINES = 2;

    localparam int MON_SCL_LVL = 0;
    localparam int MON_SDA_LVL = 1;
    localparam int MON_SCL_FRC = 2;
    localparam int MON_SDA_FRC = 3;
endpackage

// File: rtl/lw_sync.sv
module lw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lw_glitch_filter.sv
module lw_glitch_filter
    import i2c_lw_pkg::*;
#(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [FLT_W-1:0] len_i,
    output logic             level_o
);
    flt_state_e       state_q, state_d;
    logic [FLT_W-1:0] cnt_q, cnt_d;
    logic             level_q, level_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STABLE;
            cnt_q   <= '0;
            level_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        level_d = level_q;
        unique case (state_q)
            FLT_STABLE: begin
                if (raw_i != level_q) begin
                    if (len_i == '0) begin
                        level_d = raw_i;            // stable-commit
                    end else begin
                        state_d = FLT_QUAL;         // start-qualify
                        cnt_d   = FLT_W'(1);
                    end
                end
            end
            FLT_QUAL: begin
                if (raw_i == level_q) begin
                    state_d = FLT_STABLE;           // reject-bounce
                    cnt_d   = '0;
                end else if (cnt_q >= len_i) begin
                    state_d = FLT_STABLE;           // qualify-commit
                    cnt_d   = '0;
                    level_d = raw_i;
                end else begin
                    cnt_d = cnt_q + FLT_W'(1);
                end
            end
            default: begin
                state_d = FLT_STABLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign level_o = level_q;

    // A new filtered level must be the level the input showed at that edge
    p_commit_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(raw_i) == level_q));

    // An input equal to the accepted level never moves the output
    p_no_glitch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(raw_i) == $past(level_q)) |-> (level_q == $past(level_q)));

    // A qualification run always carries a nonzero count
    p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_QUAL) |-> (cnt_q != '0));
endmodule

// File: rtl/lw_force_reg.sv
module lw_force_reg
    import i2c_lw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] we_i,
    input  logic [NUM_LINES-1:0] wd_i,
    output logic [NUM_LINES-1:0] force_o
);
    logic [NUM_LINES-1:0] force_q;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_field
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     force_q[i] <= 1'b0;
                else if (we_i[i]) force_q[i] <= wd_i[i];
            end

            // A field not written keeps its value (R6 for SCL, R7 for SDA)
            p_field_hold_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !we_i[i] |=> $stable(force_q[i]));
        end
    endgenerate

    assign force_o = force_q;
endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch
    import i2c_lw_pkg::*;
#(
    parameter int FLT_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_pad_i,
    input  logic             sda_pad_i,
    input  logic             eng_scl_pull_i,
    input  logic             eng_sda_pull_i,
    input  logic [FLT_W-1:0] glitch_len_i,
    input  logic [1:0]       force_we_i,
    input  logic [1:0]       force_wd_i,
    output logic [3:0]       mon_o,
    output logic             scl_level_o,
    output logic             sda_level_o,
    output logic             scl_pull_o,
    output logic             sda_pull_o
);
    logic [NUM_LINES-1:0] pad_raw;
    logic [NUM_LINES-1:0] pad_sync;
    logic [NUM_LINES-1:0] level;
    logic [NUM_LINES-1:0] force_bits;

    assign pad_raw[LINE_SCL] = scl_pad_i;
    assign pad_raw[LINE_SDA] = sda_pad_i;

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            lw_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (pad_raw[l]),
                .q_o   (pad_sync[l])
            );
            lw_glitch_filter #(.FLT_W(FLT_W)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_i   (pad_sync[l]),
                .len_i   (glitch_len_i),
                .level_o (level[l])
            );
        end
    endgenerate

    lw_force_reg u_force (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (force_we_i),
        .wd_i    (force_wd_i),
        .force_o (force_bits)
    );

    assign scl_level_o = level[LINE_SCL];
    assign sda_level_o = level[LINE_SDA];
    assign scl_pull_o  = force_bits[LINE_SCL] | eng_scl_pull_i;
    assign sda_pull_o  = force_bits[LINE_SDA] | eng_sda_pull_i;

    always_comb begin
        mon_o              = '0;
        mon_o[MON_SCL_LVL] = level[LINE_SCL];
        mon_o[MON_SDA_LVL] = level[LINE_SDA];
        mon_o[MON_SCL_FRC] = force_bits[LINE_SCL];
        mon_o[MON_SDA_FRC] = force_bits[LINE_SDA];
    end

    // Writing a 1 into an override pulls its line low from the next cycle
    p_scl_force_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we_i[0] && force_wd_i[0]) |=> scl_pull_o);
    p_sda_force_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_we_i[1] && force_wd_i[1]) |=> sda_pull_o);
endmodule

// File: tb/i2c_line_watch_tb.sv
module i2c_line_watch_tb;
    localparam int FLT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_pad = 1'b1, sda_pad = 1'b1;
    logic             eng_scl = 1'b0, eng_sda = 1'b0;
    logic [FLT_W-1:0] glen = '0;
    logic [1:0]       fwe = '0, fwd = '0;
    logic [3:0]       mon;
    logic             scl_lvl, sda_lvl, scl_pull, sda_pull;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    i2c_line_watch #(.FLT_W(FLT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_pad_i(scl_pad), .sda_pad_i(sda_pad),
        .eng_scl_pull_i(eng_scl), .eng_sda_pull_i(eng_sda), .glitch_len_i(glen),
        .force_we_i(fwe), .force_wd_i(fwd), .mon_o(mon),
        .scl_level_o(scl_lvl), .sda_level_o(sda_lvl),
        .scl_pull_o(scl_pull), .sda_pull_o(sda_pull)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pad(input int line, input logic v);
        if (line == 0) scl_pad = v; else sda_pad = v;
    endtask

    function automatic logic lvl(input int line);
        return (line == 0) ? scl_lvl : sda_lvl;
    endfunction

    // R1 and R2: reset state and monitor bit map
    task automatic t_reset;
        chk("R1 monitor after reset", mon, 4'b0011);
        chk("R1 pulls after reset", {2'b00, sda_pull, scl_pull}, 4'b0000);
        chk("R1 levels after reset", {2'b00, sda_lvl, scl_lvl}, 4'b0011);
    endtask

    // R3 / R9: latency of L+3 edges, checked one edge early and on time
    task automatic t_latency(input int line, input int L, input string req);
        glen = FLT_W'(L);
        tick(2);
        set_pad(line, 1'b0);
        tick(L + 2);
        chk({req, " old level held"}, {3'b0, lvl(line)}, 4'b0001);
        tick(1);
        chk({req, " new level on time"}, {3'b0, lvl(line)}, 4'b0000);
        chk("R2 monitor level bit", {3'b0, mon[line]}, 4'b0000);
        set_pad(line, 1'b1);
        tick(L + 3);
        chk({req, " rising change on time"}, {3'b0, lvl(line)}, 4'b0001);
    endtask

    // R4: short pulse rejected, pulse of L+1 accepted
    task automatic t_glitch;
        int drops;
        logic seen;
        glen = FLT_W'(3);
        tick(2);
        drops = 0;
        sda_pad = 1'b0;
        tick(3);
        sda_pad = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (sda_lvl !== 1'b1) drops++;
            tick(1);
        end
        chk("R4 pulse of L rejected", 4'(drops), 4'd0);
        seen = 1'b0;
        sda_pad = 1'b0;
        tick(4);
        sda_pad = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (sda_lvl === 1'b0) seen = 1'b1;
            tick(1);
        end
        chk("R4 pulse of L+1 accepted", {3'b0, seen}, 4'b0001);
    endtask

    // R5: bounce restarts qualification
    task automatic t_bounce;
        glen = FLT_W'(4);
        tick(2);
        scl_pad = 1'b0;
        tick(3);
        scl_pad = 1'b1;
        tick(1);
        scl_pad = 1'b0;
        tick(6);
        chk("R5 count restarted, old level held", {3'b0, scl_lvl}, 4'b0001);
        tick(1);
        chk("R5 commit after full window", {3'b0, scl_lvl}, 4'b0000);
        scl_pad = 1'b1;
        tick(10);
    endtask

    // R6 / R7: independent override fields
    task automatic t_force;
        fwe = 2'b01; fwd = 2'b01;
        tick(1);
        fwe = 2'b00; fwd = 2'b00;
        chk("R6 SCL override set", {mon[3:2], sda_pull, scl_pull}, 4'b0101);
        fwe = 2'b10; fwd = 2'b10;
        tick(1);
        fwe = 2'b00; fwd = 2'b00;
        chk("R7 SDA set, SCL kept", {mon[3:2], sda_pull, scl_pull}, 4'b1111);
        fwe = 2'b01; fwd = 2'b00;
        tick(1);
        fwe = 2'b00;
        chk("R6 SCL cleared, SDA kept", {mon[3:2], sda_pull, scl_pull}, 4'b1010);
        fwe = 2'b10; fwd = 2'b00;
        tick(1);
        fwe = 2'b00;
        chk("R7 SDA cleared", {mon[3:2], sda_pull, scl_pull}, 4'b0000);
    endtask

    // R8: engine request ORed with override, no clock delay
    task automatic t_engine;
        eng_scl = 1'b1;
        #1;
        chk("R8 engine SCL request", {2'b00, sda_pull, scl_pull}, 4'b0001);
        eng_scl = 1'b0; eng_sda = 1'b1;
        #1;
        chk("R8 engine SDA request", {2'b00, sda_pull, scl_pull}, 4'b0010);
        eng_sda = 1'b0;
        #1;
        chk("R8 both released", {2'b00, sda_pull, scl_pull}, 4'b0000);
        tick(1);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_latency(0, 5, "R3 SCL");
        t_latency(1, 2, "R3 SDA");
        t_latency(0, 0, "R9 SCL");
        t_glitch();
        t_bounce();
        t_force();
        t_engine();
        summary();
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end
endmodule